// File: doc/BRIEF.md
# Single-cycle integer execution datapath

This block is the datapath of a simplified single-cycle 32-bit integer processor. It holds the program counter, thirty-two general registers, immediate extraction for the load/ALU-immediate, store and conditional-branch formats, the ALU, the operand and write-back selectors, and the adder that forms the branch target. An external controller decodes each fetched instruction and steers the block through a handful of select and enable strobes.

Each cycle, the fetched word arrives on `instr`. The block reads its two source registers and computes an ALU result, which is also the data-memory address. It offers the second source register as store data, and chooses between the ALU result and the memory read data for write-back. On the clock edge it writes the destination register and, when asked to, advances or redirects the program counter. Instruction memory, data memory and the decoder are outside the block.

Top module: `sc_datapath`

## Requirements
- R1: A clock edge with `rst` high loads `pc` with the parameter `RESET_PC` (default 0x00400000).
- R2: A clock edge with `rst` low and `pc_load` low leaves `pc` unchanged.
- R3: A clock edge with `pc_load` high and `pc_sel` low sets `pc` to its old value plus 4.
- R4: A clock edge with `pc_load` high and `pc_sel` high sets `pc` to the old `pc` plus the branch offset. The offset is a sign-extended 13-bit value with bit 0 = 0. Its bits come from `instr`: offset[12]=instr[31], offset[11]=instr[7], offset[10:5]=instr[30:25], offset[4:1]=instr[11:8].
- R5: The two source register numbers are instr[19:15] and instr[24:20], and the destination is instr[11:7]. Register reads are combinational. A rising edge with `rf_we` high writes `wb_data` to the destination.
- R6: Register 0 always reads as zero, and writes to it have no effect.
- R7: ALU operand A is source register 1. Operand B is source register 2 when `op2_sel`=0. When `op2_sel`=1 it is an immediate: instr[31:20] sign-extended, or {instr[31:25], instr[11:7]} sign-extended when instr[6:0] = 7'b0100011.
- R8: `alu_op` selects the operation: 0000 AND, 0001 OR, 0010 ADD, 0110 SUB, 0111 signed set-less-than (result 1 or 0), 1101 XOR. Every other code gives the ADD result.
- R9: `alu_zero` is high exactly when the ALU result is zero.
- R10: `mem_addr` is the ALU result, and `mem_wdata` is the value of source register 2.
- R11: `wb_data` is the ALU result when `wb_sel`=0 and `mem_rdata` when `wb_sel`=1. The same value is written to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the program counter |
| instr | input | 32 | Fetched instruction word |
| pc_sel | input | 1 | Next-PC choice: 0 sequential, 1 branch target |
| op2_sel | input | 1 | ALU operand B choice: 0 register, 1 immediate |
| rf_we | input | 1 | Register write enable |
| wb_sel | input | 1 | Write-back choice: 0 ALU result, 1 memory data |
| alu_op | input | 4 | ALU operation code |
| pc_load | input | 1 | Update strobe for the program counter |
| pc | output | 32 | Current program counter |
| alu_zero | output | 1 | ALU result equals zero |
| mem_addr | output | 32 | Data-memory address (ALU result) |
| mem_wdata | output | 32 | Store data (source register 2) |
| mem_rdata | input | 32 | Data read from data memory |
| wb_data | output | 32 | Value returned to the register file |

## Verification
The embedded assertions check the following on every clock:
- the program-counter rules: reset vector, hold, sequential step and branch step;
- agreement between the zero flag and the address output;
- register 0 reading as zero;
- the write-back selection.

Only the bench's scenarios can show the rest:
- that each ALU code produces the right value;
- that the store-format immediate is picked over the load/ALU form;
- that sign extension is correct at the 12-bit and 13-bit extremes;
- that results written to the register file are read back correctly in later instructions, including a write aimed at register 0 that leaves nothing behind.

// File: rtl/sc_datapath.sv
module sc_datapath #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic        pc_sel,
  input  logic        op2_sel,
  input  logic        rf_we,
  input  logic        wb_sel,
  input  logic [3:0]  alu_op,
  input  logic        pc_load,
  output logic [31:0] pc,
  output logic        alu_zero,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [31:0] wb_data
);

  localparam logic [6:0] OPC_STORE = 7'b0100011;

  logic [31:0] rf [1:31];
  logic [4:0]  ra, rb, rd;
  logic [31:0] a_val, b_val, imm_i, imm_s, imm_b, op_b, res;
  logic        unused_funct3;

  assign ra = instr[19:15];
  assign rb = instr[24:20];
  assign rd = instr[11:7];
  assign unused_funct3 = ^instr[14:12];

  assign a_val = (ra == 5'd0) ? 32'd0 : rf[ra];
  assign b_val = (rb == 5'd0) ? 32'd0 : rf[rb];

  assign imm_i = {{20{instr[31]}}, instr[31:20]};
  assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
  assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};

  assign op_b = !op2_sel ? b_val : (instr[6:0] == OPC_STORE) ? imm_s : imm_i;

  always_comb begin
    case (alu_op)
      4'b0000: res = a_val & op_b;
      4'b0001: res = a_val | op_b;
      4'b0110: res = a_val - op_b;
      4'b0111: res = {31'd0, $signed(a_val) < $signed(op_b)};
      4'b1101: res = a_val ^ op_b;
      default: res = a_val + op_b;
    endcase
  end

  assign alu_zero  = (res == 32'd0);
  assign mem_addr  = res;
  assign mem_wdata = b_val;
  assign wb_data   = wb_sel ? mem_rdata : res;

  always_ff @(posedge clk) begin
    if (rf_we && rd != 5'd0) rf[rd] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          pc <= RESET_PC;
    else if (pc_load) pc <= pc_sel ? pc + imm_b : pc + 32'd4;
  end

  p_reset_vector_r1: assert property (@(posedge clk) rst |=> pc == RESET_PC);
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pc_load |=> $stable(pc));
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    pc_load && !pc_sel |=> pc == $past(pc) + 32'd4);
  p_pc_branch_r4: assert property (@(posedge clk) disable iff (rst)
    pc_load && pc_sel |=> pc == $past(pc) + $past(imm_b));
  p_x0_zero_r6: assert property (@(posedge clk) disable iff (rst)
    instr[24:20] == 5'd0 |-> mem_wdata == 32'd0);
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    alu_zero == (mem_addr == 32'd0));
  p_wb_mem_r11: assert property (@(posedge clk) disable iff (rst)
    wb_sel |-> wb_data == mem_rdata);
  p_wb_alu_r11: assert property (@(posedge clk) disable iff (rst)
    !wb_sel |-> wb_data == mem_addr);

endmodule

// File: tb/sim_sc_datapath.sv
module sim_sc_datapath;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [31:0] instr = '0, mem_rdata = '0;
  logic pc_sel = 0, op2_sel = 0, rf_we = 0, wb_sel = 0, pc_load = 0;
  logic [3:0] alu_op = '0;
  logic [31:0] pc, mem_addr, mem_wdata, wb_data;
  logic alu_zero;

  sc_datapath #(.RESET_PC(RV)) u0 (
    .clk(clk), .rst(rst), .instr(instr), .pc_sel(pc_sel), .op2_sel(op2_sel),
    .rf_we(rf_we), .wb_sel(wb_sel), .alu_op(alu_op), .pc_load(pc_load),
    .pc(pc), .alu_zero(alu_zero), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_data(wb_data));

  int checks = 0, errors = 0;
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  localparam logic [3:0] AND_ = 4'b0000, OR_ = 4'b0001, ADD = 4'b0010,
                         SUB = 4'b0110, SLT = 4'b0111, XOR_ = 4'b1101;

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] s2, s1,
                                        input logic [2:0] f3, input logic [4:0] d);
    return {f7, s2, s1, f3, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] s1,
                                        input logic [4:0] d, input logic [6:0] opc);
    return {im, s1, 3'b000, d, opc};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] s2, s1);
    return {im[11:5], s2, s1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] s2, s1);
    return {im[12], im[10:5], s2, s1, 3'b000, im[4:1], im[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] model_alu(input logic [31:0] a, b, input logic [3:0] op);
    case (op)
      AND_:    return a & b;
      OR_:     return a | b;
      SUB:     return a - b;
      SLT:     return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      XOR_:    return a ^ b;
      default: return a + b;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; pc_load = 0; rf_we = 0;
    @(posedge clk); #1 m_pc = RV;
    @(negedge clk); rst = 0;
    #1 chk("R1", "pc after reset", pc, RV);
  endtask

  // imm: expected immediate (operand B when osel) or branch offset
  task automatic step(input logic [31:0] ins, input logic [31:0] imm, input logic psel, osel,
                      input logic we, wsel, input logic [3:0] op, input logic load,
                      input logic [31:0] rdata, input string tag);
    logic [31:0] a, b, r, wb;
    logic [4:0] s1, s2, d;
    @(negedge clk);
    instr = ins; pc_sel = psel; op2_sel = osel; rf_we = we; wb_sel = wsel;
    alu_op = op; pc_load = load; mem_rdata = rdata;
    s1 = ins[19:15]; s2 = ins[24:20]; d = ins[11:7];
    a = (s1 == 0) ? 32'd0 : m_rf[s1];
    b = (s2 == 0) ? 32'd0 : m_rf[s2];
    r = model_alu(a, osel ? imm : b, op);
    wb = wsel ? rdata : r;
    #2;
    chk(tag, "pc", pc, m_pc);
    chk(tag, "mem_addr", mem_addr, r);
    chk(tag, "mem_wdata", mem_wdata, b);
    chk(tag, "alu_zero", {31'd0, alu_zero}, {31'd0, r == 32'd0});
    chk(tag, "wb_data", wb_data, wb);
    @(posedge clk); #1;
    if (we && d != 0) m_rf[d] = wb;
    if (load) m_pc = psel ? m_pc + imm : m_pc + 32'd4;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [6:0] OP_I = 7'b0010011, OP_L = 7'b0000011;

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    do_reset();
    // R7 I-type immediates at the extremes
    step(enc_i(12'hff9, 0, 1, OP_I), 32'hffff_fff9, 0, 1, 1, 0, ADD, 1, 0, "R7 addi -7");
    step(enc_i(12'h7ff, 0, 2, OP_I), 32'h0000_07ff, 0, 1, 1, 0, ADD, 1, 0, "R7 addi 2047");
    step(enc_i(12'h800, 0, 3, OP_I), 32'hffff_f800, 0, 1, 1, 0, ADD, 1, 0, "R7 addi -2048");
    // R8 register-register ops, R5 readback, R3 sequential pc
    step(enc_r(0, 2, 1, 0, 4), 0, 0, 0, 1, 0, ADD, 1, 0, "R8 add");
    step(enc_r(7'h20, 2, 1, 0, 5), 0, 0, 0, 1, 0, SUB, 1, 0, "R8 sub");
    step(enc_r(0, 3, 2, 7, 6), 0, 0, 0, 1, 0, AND_, 1, 0, "R8 and");
    step(enc_r(0, 3, 2, 6, 7), 0, 0, 0, 1, 0, OR_, 1, 0, "R8 or");
    step(enc_r(0, 3, 1, 4, 8), 0, 0, 0, 1, 0, XOR_, 1, 0, "R8 xor");
    step(enc_r(0, 2, 1, 2, 9), 0, 0, 0, 1, 0, SLT, 1, 0, "R8 slt neg<pos");
    step(enc_r(0, 1, 2, 2, 10), 0, 0, 0, 1, 0, SLT, 1, 0, "R8 slt pos<neg");
    step(enc_r(0, 2, 1, 0, 11), 0, 0, 0, 1, 0, 4'b0011, 1, 0, "R8 default add");
    step(enc_r(0, 9, 4, 0, 15), 0, 0, 0, 1, 0, ADD, 1, 0, "R5 readback");
    // R6 write to x0 ignored
    step(enc_i(12'h005, 2, 0, OP_I), 32'd5, 0, 1, 1, 0, ADD, 1, 0, "R6 write x0");
    step(enc_r(0, 0, 0, 0, 12), 0, 0, 0, 1, 0, ADD, 1, 0, "R6 read x0");
    // R2 hold
    step(enc_r(0, 2, 1, 0, 16), 0, 0, 0, 1, 0, ADD, 0, 0, "R2 hold");
    step(enc_r(0, 2, 1, 0, 16), 0, 0, 0, 0, 0, ADD, 0, 0, "R2 hold again");
    // R7 S-format immediate, R10 address and store data
    step(enc_s(12'hfec, 2, 1), 32'hffff_ffec, 0, 1, 0, 0, ADD, 1, 0, "R10 sw");
    step(enc_s(12'h7ff, 3, 2), 32'h0000_07ff, 0, 1, 0, 0, ADD, 1, 0, "R7 sw max");
    // R11 load write-back
    step(enc_i(12'h008, 2, 13, OP_L), 32'd8, 0, 1, 1, 1, ADD, 1, 32'hdead_beef, "R11 lw");
    step(enc_r(0, 0, 13, 0, 14), 0, 0, 0, 1, 0, ADD, 1, 0, "R11 lw readback");
    // R4 branches, R9 zero flag
    step(enc_b(13'd56, 1, 1), 32'd56, 1, 0, 0, 0, SUB, 1, 0, "R4 beq taken fwd");
    step(enc_b(13'h1ff8, 2, 1), 32'hffff_fff8, 0, 0, 0, 0, SUB, 1, 0, "R9 beq not taken");
    step(enc_b(13'h1000, 2, 2), 32'hffff_f000, 1, 0, 0, 0, SUB, 1, 0, "R4 beq min offset");
    step(enc_b(13'h0ffe, 3, 3), 32'h0000_0ffe, 1, 0, 0, 0, SUB, 1, 0, "R4 beq max offset");
    step(enc_r(0, 0, 0, 0, 0), 0, 0, 0, 0, 0, ADD, 0, 0, "R3 final");
    // R1 reset mid-run
    do_reset();
    step(enc_i(12'h001, 0, 17, OP_I), 32'd1, 0, 1, 1, 0, ADD, 1, 0, "R3 after reset");
    @(negedge clk); #1 chk("R3", "pc end", pc, m_pc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule